// File: doc/BRIEF.md
# Write Protection Unlock Sequencer

This block sits between the bus front end of a non-volatile memory and its page write engine and keeps stray bus cycles from changing the array. Every write that the front end decodes arrives as a one-cycle pulse together with its address and data byte. While the block is locked, it discards every write. It watches for three key writes, each with a fixed address and data value, arriving in a fixed order. Once it has seen all three, it opens. While open, every write passes to the page write engine as a gated pulse with its address and byte.

The byte-load window is timed outside the block, and the block learns of its expiry through a timeout pulse. A timeout before the key sequence is complete drops the block back to locked. A timeout while open closes the page. If the page holds at least one data byte, the block waits in a busy state until the programming cycle reports completion, and then relocks. If the page is empty, the block relocks at once. The key addresses and data values are parameters.

Top module: `wps_unlock_seq`

## Requirements
- R1: In the first cycle after a synchronous reset, `unlocked` is 0 and `gw_stb` is 0.
- R2: Unlocking requires the writes data 0xAA to address 0x5555, then data 0x55 to address 0x2AAA, then data 0xA0 to address 0x5555, in that order. A key write out of its turn does not advance the sequence.
- R3: No key write of the unlock sequence ever produces a pulse on `gw_stb`.
- R4: `unlocked` reads 1 from the first cycle after the clock edge that takes the third key write.
- R5: While the sequence is partly entered, a write that does not match the next key returns the block to locked, and that write is discarded.
- R6: A timeout pulse while the sequence is partly entered returns the block to locked.
- R7: While unlocked, each write pulse gives one `gw_stb` pulse one cycle later, with `gw_addr` and `gw_data` equal to the address and data of that write.
- R8: A timeout while unlocked, after at least one forwarded write, clears `unlocked`. All writes are then discarded, key writes included, until `prog_done` pulses. After that pulse the block is locked and needs the full key sequence again.
- R9: A timeout while unlocked with no write forwarded since unlocking relocks the block at once, without waiting for `prog_done`.
- R10: A write that arrives in the same cycle as a timeout is discarded, and the timeout takes effect.
- R11: While locked, a write that is not the first key is discarded and leaves the block locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle write pulse from the bus front end |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | DATA_W | Data byte of the write |
| win_expired | input | 1 | One-cycle pulse: the byte-load window has expired |
| prog_done | input | 1 | One-cycle pulse: the array programming cycle has finished |
| gw_stb | output | 1 | Registered write pulse forwarded to the page write engine |
| gw_addr | output | ADDR_W | Address forwarded with `gw_stb` |
| gw_data | output | DATA_W | Data forwarded with `gw_stb` |
| unlocked | output | 1 | High while data writes are being accepted |

## Verification
A write taken at clock edge N produces its `gw_stb` pulse, address and data in the cycle after edge N, with one register on the path. The effect of a key write, a timeout or `prog_done` shows on `unlocked` in that same cycle, because `unlocked` decodes the state register directly. The bench drives its inputs on falling edges. A behavioural model updates its expected outputs on each rising edge from the inputs present at that edge, and the outputs are compared with the model on the following falling edge, every cycle. Each comparison is therefore made half a cycle after the edge that should have produced the result.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [2:0] {
    ST_LOCKED = 3'd0,
    ST_KEY1   = 3'd1,
    ST_KEY2   = 3'd2,
    ST_OPEN   = 3'd3,
    ST_BUSY   = 3'd4
  } wps_state_t;

  localparam int unsigned KEY_STEPS = 3;
endpackage

// File: rtl/wps_key_match.sv
module wps_key_match #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STEPS  = 3,
  parameter logic [STEPS*ADDR_W-1:0] KEY_ADDRS = '0,
  parameter logic [STEPS*DATA_W-1:0] KEY_DATAS = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [STEPS-1:0]  hit
);
  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign hit[i] = (addr == KEY_ADDRS[i*ADDR_W +: ADDR_W]) &&
                    (data == KEY_DATAS[i*DATA_W +: DATA_W]);
  end
endmodule

// File: rtl/wps_seq_fsm.sv
module wps_seq_fsm
  import wps_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_stb,
  input  logic                 win_expired,
  input  logic                 prog_done,
  input  logic [KEY_STEPS-1:0] key_hit,
  output logic                 fwd,
  output logic                 unlocked
);
  wps_state_t state_q, state_n;
  logic       dirty_q;

  always_comb begin
    state_n = state_q;
    fwd     = 1'b0;
    if (state_q == ST_BUSY) begin
      if (prog_done) state_n = ST_LOCKED;
    end else if (win_expired) begin
      state_n = (state_q == ST_OPEN && dirty_q) ? ST_BUSY : ST_LOCKED;
    end else if (wr_stb) begin
      case (state_q)
        ST_LOCKED: if (key_hit[0]) state_n = ST_KEY1;
        ST_KEY1:   state_n = key_hit[1] ? ST_KEY2 : ST_LOCKED;
        ST_KEY2:   state_n = key_hit[2] ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   fwd = 1'b1;
        default:   state_n = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LOCKED;
      dirty_q <= 1'b0;
    end else begin
      state_q <= state_n;
      dirty_q <= (state_n == ST_OPEN) ? (dirty_q | fwd) : 1'b0;
    end
  end

  assign unlocked = (state_q == ST_OPEN);

  // A timeout never leaves the block open.
  assert_timeout_closes_R6: assert property (@(posedge clk) disable iff (rst)
    win_expired |=> !unlocked);

  // Opening only follows a write that matched the last key.
  assert_open_after_key_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(wr_stb && key_hit[KEY_STEPS-1]));

  // Busy waits for the programming cycle to finish.
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY && !prog_done) |=> (state_q == ST_BUSY));
endmodule

// File: rtl/wps_fwd_reg.sv
module wps_fwd_reg #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwd,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_stb,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) out_stb <= 1'b0;
    else     out_stb <= fwd;
  end

  always_ff @(posedge clk) begin
    if (fwd) begin
      out_addr <= in_addr;
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/wps_unlock_seq.sv
module wps_unlock_seq
  import wps_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [KEY_STEPS*ADDR_W-1:0] KEY_ADDRS = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [KEY_STEPS*DATA_W-1:0] KEY_DATAS = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_expired,
  input  logic              prog_done,
  output logic              gw_stb,
  output logic [ADDR_W-1:0] gw_addr,
  output logic [DATA_W-1:0] gw_data,
  output logic              unlocked
);
  logic [KEY_STEPS-1:0] key_hit;
  logic                 fwd;

  wps_key_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEPS(KEY_STEPS),
    .KEY_ADDRS(KEY_ADDRS), .KEY_DATAS(KEY_DATAS)
  ) u_match (
    .addr(wr_addr), .data(wr_data), .hit(key_hit)
  );

  wps_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .win_expired(win_expired),
    .prog_done(prog_done), .key_hit(key_hit), .fwd(fwd), .unlocked(unlocked)
  );

  wps_fwd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
    .clk(clk), .rst(rst), .fwd(fwd), .in_addr(wr_addr), .in_data(wr_data),
    .out_stb(gw_stb), .out_addr(gw_addr), .out_data(gw_data)
  );

  // Nothing reaches the page engine unless the block was open, a write was
  // present and no timeout was competing with it.
  assert_no_fwd_when_closed_R3: assert property (@(posedge clk) disable iff (rst)
    gw_stb |-> $past(unlocked && wr_stb && !win_expired));

  // The forwarded payload is the one carried by the accepted write.
  assert_payload_matches_R7: assert property (@(posedge clk) disable iff (rst)
    gw_stb |-> (gw_addr == $past(wr_addr) && gw_data == $past(wr_data)));

  // An accepted write while open always leads to a pulse.
  assert_open_write_forwarded_R7: assert property (@(posedge clk) disable iff (rst)
    (unlocked && wr_stb && !win_expired) |=> gw_stb);
endmodule

// File: tb/wps_unlock_seq_bench.sv
module wps_unlock_seq_bench;
  localparam int AW = 15;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          win_expired = 1'b0;
  logic          prog_done = 1'b0;
  logic          gw_stb;
  logic [AW-1:0] gw_addr;
  logic [DW-1:0] gw_data;
  logic          unlocked;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  wps_unlock_seq u_wps_unlock_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_expired(win_expired), .prog_done(prog_done),
    .gw_stb(gw_stb), .gw_addr(gw_addr), .gw_data(gw_data), .unlocked(unlocked)
  );

  // Behavioural reference: 0 locked, 1..2 keys seen, 3 open, 4 busy.
  int      m_st = 0;
  bit      m_dirty = 0;
  bit      e_stb = 0;
  int      e_addr = 0;
  int      e_data = 0;

  always @(posedge clk) begin
    e_stb = 0;
    if (rst) begin
      m_st = 0; m_dirty = 0;
    end else if (m_st == 4) begin
      if (prog_done) m_st = 0;
    end else if (win_expired) begin
      m_st = (m_st == 3 && m_dirty) ? 4 : 0;
      m_dirty = 0;
    end else if (wr_stb) begin
      if (m_st == 3) begin
        e_stb = 1; e_addr = wr_addr; e_data = wr_data; m_dirty = 1;
      end else if (m_st == 0) begin
        if (wr_addr == 'h5555 && wr_data == 'hAA) m_st = 1;
      end else if (m_st == 1) begin
        m_st = (wr_addr == 'h2AAA && wr_data == 'h55) ? 2 : 0;
      end else if (m_st == 2) begin
        m_st = (wr_addr == 'h5555 && wr_data == 'hA0) ? 3 : 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if (gw_stb !== e_stb) begin
        bad++;
        $display("FAIL %s gw_stb actual=%0b expected=%0b", tag, gw_stb, e_stb);
      end
      total++;
      if (unlocked !== (m_st == 3)) begin
        bad++;
        $display("FAIL %s unlocked actual=%0b expected=%0b", tag, unlocked, m_st == 3);
      end
      if (e_stb) begin
        total++;
        if (gw_addr !== AW'(e_addr) || gw_data !== DW'(e_data)) begin
          bad++;
          $display("FAIL %s payload actual=%h/%h expected=%h/%h",
                   tag, gw_addr, gw_data, AW'(e_addr), DW'(e_data));
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_stb = 1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic wr_tmo(input int a, input int d);
    @(negedge clk);
    wr_stb = 1; wr_addr = AW'(a); wr_data = DW'(d); win_expired = 1;
    @(negedge clk);
    wr_stb = 0; win_expired = 0;
  endtask

  task automatic tmo();
    @(negedge clk); win_expired = 1;
    @(negedge clk); win_expired = 0;
  endtask

  task automatic pdone();
    @(negedge clk); prog_done = 1;
    @(negedge clk); prog_done = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'hA0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    tag = "R1"; idle(3);
    @(negedge clk); rst = 0;
    idle(3);

    tag = "R11"; wr('h1234, 'h5A); wr('h5555, 'hA0); wr('h2AAA, 'h55); idle(2);
    tag = "R2";  wr('h2AAA, 'h55); wr('h5555, 'hA0); wr('h0010, 'h11); idle(2);

    tag = "R3";  unlock();
    tag = "R4";  idle(2);
    tag = "R7";  wr('h0100, 'h01); wr('h0101, 'h02); wr('h5555, 'hAA); wr('h017F, 'hFF);
    tag = "R8";  tmo(); wr('h0102, 'h33); unlock(); wr('h0103, 'h44); idle(3);
    pdone(); wr('h0104, 'h55); idle(2);

    tag = "R5";  wr('h5555, 'hAA); wr('h2AAA, 'h56); wr('h5555, 'hA0); wr('h0200, 'h66);
    wr('h5555, 'hAA); wr('h2AAB, 'h55); wr('h0201, 'h67);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5554, 'hA0); wr('h0202, 'h68); idle(2);

    tag = "R6";  wr('h5555, 'hAA); tmo(); wr('h2AAA, 'h55); wr('h5555, 'hA0); wr('h0300, 'h77);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); tmo(); wr('h5555, 'hA0); wr('h0301, 'h78); idle(2);

    tag = "R9";  unlock(); tmo(); wr('h0400, 'h88); pdone(); wr('h0401, 'h89); idle(2);

    tag = "R10"; unlock(); wr_tmo('h0500, 'h99); wr('h0501, 'h9A); idle(2);
    unlock(); wr('h0502, 'h9B); wr_tmo('h0503, 'h9C); wr('h0504, 'h9D); pdone();
    wr('h0505, 'h9E); idle(2);

    tag = "R1";  @(negedge clk); rst = 1; idle(2); @(negedge clk); rst = 0; idle(2);
    tag = "R7";  unlock(); wr('h7FFF, 'h00); wr('h0000, 'hFF); tmo(); pdone(); idle(3);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule